// File: doc/BRIEF.md
# Linked-Descriptor Buffer Transfer Engine

This block follows a chain of transfer descriptors held in memory. For each buffer a descriptor names, it hands one request to a data mover. Each descriptor is four 32-bit words, in this order: a control word, a word holding the two buffer lengths, the address of the first buffer, and a fourth word. The fourth word is either the address of the second buffer or a pointer to the next descriptor.

Software sets the ownership bit in each control word, programs the list base, and raises the enable. The engine then fetches the descriptors one by one over a simple word-read and word-write memory port and issues the transfers. After each descriptor it writes the control word back with ownership returned to software.

A sticky status register, cleared by writing ones, records these events:
- the end of a list;
- a descriptor that software still owns;
- a memory bus error.

An interrupt output summarises the status register under per-direction enables.

Top module: `desc_dma_engine`

## Requirements
- R1: After the synchronous reset `rst`, `status` is 0, `irq` is 0, and neither `mem_req` nor `mv_req` is asserted.
- R2: A walk starts when `cfg_enable` goes from 0 to 1 while the engine is idle. The first four memory reads use addresses base, base+4, base+8 and base+12, where base is `cfg_base`.
- R3: For each buffer, one `mv_req` is issued and held until `mv_done`. The request carries:
  - the buffer address;
  - the length from the size word, where the first buffer uses bits 15:0 and the second uses bits 31:16, and a length field of 0 means 65536;
  - the direction latched from `cfg_dir` at the start of the walk (1 = transmit).
- R4: When control bit 4 (chain) is set, only the first buffer is transferred and the next descriptor is fetched from the address in word 3.
- R5: When control bit 4 is clear, word 3 is the second buffer's address, and that buffer is transferred only if its length field is nonzero. The next descriptor lies at the current address + 16. If control bit 5 (ring end) is set, the next descriptor is at the base instead.
- R6: After its buffers finish, a descriptor's control word is written back with bit 31 (owner) cleared. Bit 30 is set if the mover reported `mv_err` for any of its buffers, and all other bits are kept.
- R7: After a descriptor with control bit 2 (last) is written back, the engine goes idle. Unless control bit 1 (interrupt disable) is set, it also sets status bit 0 (transmit done) or bit 1 (receive done) according to the direction, together with bit 8 (normal summary).
- R8: If a fetched descriptor has bit 31 clear, the engine issues no transfer and goes idle. It sets status bit 4 (invalid descriptor), bit 5 (error summary) and bit 9 (abnormal summary).
- R9: A `mem_err` on any memory access stops the walk and sets status bits 2 (bus error), 5 and 9.
- R10: Status bits are sticky. Writing with `sts_clr_we` clears exactly the bits that are 1 in `sts_clr_mask`.
- R11: `irq` equals (status bit 0 AND `cfg_tx_ie`) OR (status bit 1 AND `cfg_rx_ie`) OR status bit 9.
- R12: A `cfg_reset` pulse abandons the walk. From the next cycle no memory or mover request is made and no write-back occurs, and `status` is unchanged.
- R13: `mv_fixed` carries the `cfg_fixburst` value latched at the start of the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | AW | Address of the first descriptor |
| cfg_enable | input | 1 | Rising edge starts a walk |
| cfg_reset | input | 1 | Pulse abandons the walk |
| cfg_dir | input | 1 | 1 = transmit, 0 = receive |
| cfg_fixburst | input | 1 | Fixed-burst request for the mover |
| cfg_tx_ie | input | 1 | Transmit-done interrupt enable |
| cfg_rx_ie | input | 1 | Receive-done interrupt enable |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 10 | Bits to clear |
| status | output | 10 | Sticky status |
| irq | output | 1 | Interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed, valid with ack |
| mv_req | output | 1 | Buffer transfer request |
| mv_addr | output | AW | Buffer address |
| mv_len | output | 17 | Buffer length in bytes |
| mv_dir | output | 1 | Transfer direction |
| mv_fixed | output | 1 | Fixed-burst flag |
| mv_done | input | 1 | Transfer complete pulse |
| mv_err | input | 1 | Transfer error, valid with done |

## Verification
The bench sweeps chains of one to four linked descriptors across both directions and both settings of the last descriptor's interrupt-disable bit. The chains are spaced irregularly, so an engine that assumed contiguous descriptors would fetch the wrong words. A zero length field is included, and a design that passed it through would issue a zero-byte request instead of a 65536-byte one. A ring test mixes two-buffer and one-buffer descriptors and injects a mover error. It then wraps back to an already-returned descriptor, which catches a skipped second buffer, a lost error flag in the write-back, and a missing invalid-descriptor stop. Further tests inject a bus error in mid-fetch and abandon a transfer with a reset pulse; a design that wrote back or cleared status there would be caught.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int WORD_W   = 32;
  localparam int DESC_WORDS = 4;
  localparam int LEN_W    = 16;
  localparam int STATUS_W = 10;

  // control word bit positions
  localparam int C_OWN   = 31;
  localparam int C_ERR   = 30;
  localparam int C_NOIRQ = 1;
  localparam int C_LAST  = 2;
  localparam int C_CHAIN = 4;
  localparam int C_RING  = 5;

  // status bit positions
  localparam int S_TXDONE = 0;
  localparam int S_RXDONE = 1;
  localparam int S_BUSERR = 2;
  localparam int S_INVAL  = 4;
  localparam int S_ERRSUM = 5;
  localparam int S_NORM   = 8;
  localparam int S_ABN    = 9;

  typedef enum logic [2:0] {
    W_IDLE, W_FETCH, W_CHECK, W_BUF1, W_BUF2, W_WBACK
  } walk_state_t;
endpackage

// File: rtl/dma_desc_regs.sv
module dma_desc_regs #(
  parameter int NWORDS = 4,
  parameter int DW     = 32,
  localparam int IW    = $clog2(NWORDS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IW-1:0]              wr_idx,
  input  logic [DW-1:0]              wr_data,
  output logic [NWORDS-1:0][DW-1:0]  words
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words[g] <= '0;
      else if (wr_en && wr_idx == IW'(g))
        words[g] <= wr_data;
    end
  end
endmodule

// File: rtl/dma_status.sv
module dma_status #(
  parameter int SW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] set_vec,
  input  logic          clr_we,
  input  logic [SW-1:0] clr_mask,
  input  logic          tx_ie,
  input  logic          rx_ie,
  output logic [SW-1:0] status,
  output logic          irq
);
  import dma_pkg::*;

  logic [SW-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_eff) | set_vec;
  end

  assign irq = (status[S_TXDONE] & tx_ie) | (status[S_RXDONE] & rx_ie) | status[S_ABN];
endmodule

// File: rtl/dma_walker.sv
module dma_walker #(
  parameter int AW = 32,
  localparam int DW = dma_pkg::WORD_W,
  localparam int NW = dma_pkg::DESC_WORDS,
  localparam int IW = $clog2(NW),
  localparam int LW = dma_pkg::LEN_W,
  localparam int SW = dma_pkg::STATUS_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [AW-1:0]          cfg_base,
  input  logic                   cfg_enable,
  input  logic                   cfg_reset,
  input  logic                   cfg_dir,
  input  logic                   cfg_fixburst,
  input  logic [NW-1:0][DW-1:0]  desc,
  output logic                   cap_we,
  output logic [IW-1:0]          cap_idx,
  output logic [DW-1:0]          cap_data,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_wdata,
  input  logic [DW-1:0]          mem_rdata,
  input  logic                   mem_ack,
  input  logic                   mem_err,
  output logic                   mv_req,
  output logic [AW-1:0]          mv_addr,
  output logic [LW:0]            mv_len,
  output logic                   mv_dir,
  output logic                   mv_fixed,
  input  logic                   mv_done,
  input  logic                   mv_err,
  output logic [SW-1:0]          set_vec
);
  import dma_pkg::*;

  walk_state_t   state;
  logic [AW-1:0] cur_q, base_q;
  logic [IW-1:0] idx_q;
  logic          en_q, dir_q, fix_q, err_q;

  logic [DW-1:0] ctrl_w, size_w;
  logic [LW-1:0] len_field;
  logic [AW-1:0] next_addr;
  logic          chained, has_buf2;

  assign ctrl_w    = desc[0];
  assign size_w    = desc[1];
  assign chained   = ctrl_w[C_CHAIN];
  assign has_buf2  = !chained && (size_w[2*LW-1:LW] != '0);
  assign next_addr = chained           ? desc[3][AW-1:0] :
                     ctrl_w[C_RING]    ? base_q :
                                         cur_q + AW'(NW * 4);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= W_IDLE;
      cur_q   <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      en_q    <= 1'b0;
      dir_q   <= 1'b0;
      fix_q   <= 1'b0;
      err_q   <= 1'b0;
      set_vec <= '0;
    end else begin
      en_q    <= cfg_enable;
      set_vec <= '0;
      if (cfg_reset) begin
        state <= W_IDLE;
      end else begin
        unique case (state)
          W_IDLE: if (cfg_enable && !en_q) begin
            cur_q  <= cfg_base;
            base_q <= cfg_base;
            idx_q  <= '0;
            dir_q  <= cfg_dir;
            fix_q  <= cfg_fixburst;
            state  <= W_FETCH;
          end
          W_FETCH: if (mem_ack) begin
            if (mem_err) begin
              set_vec[S_BUSERR] <= 1'b1;
              set_vec[S_ERRSUM] <= 1'b1;
              set_vec[S_ABN]    <= 1'b1;
              state <= W_IDLE;
            end else if (idx_q == IW'(NW - 1)) begin
              state <= W_CHECK;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          W_CHECK: begin
            err_q <= 1'b0;
            if (!ctrl_w[C_OWN]) begin
              set_vec[S_INVAL]  <= 1'b1;
              set_vec[S_ERRSUM] <= 1'b1;
              set_vec[S_ABN]    <= 1'b1;
              state <= W_IDLE;
            end else begin
              state <= W_BUF1;
            end
          end
          W_BUF1: if (mv_done) begin
            err_q <= err_q | mv_err;
            state <= has_buf2 ? W_BUF2 : W_WBACK;
          end
          W_BUF2: if (mv_done) begin
            err_q <= err_q | mv_err;
            state <= W_WBACK;
          end
          W_WBACK: if (mem_ack) begin
            if (mem_err) begin
              set_vec[S_BUSERR] <= 1'b1;
              set_vec[S_ERRSUM] <= 1'b1;
              set_vec[S_ABN]    <= 1'b1;
              state <= W_IDLE;
            end else if (ctrl_w[C_LAST]) begin
              if (!ctrl_w[C_NOIRQ]) begin
                set_vec[dir_q ? S_TXDONE : S_RXDONE] <= 1'b1;
                set_vec[S_NORM] <= 1'b1;
              end
              state <= W_IDLE;
            end else begin
              cur_q <= next_addr;
              idx_q <= '0;
              state <= W_FETCH;
            end
          end
          default: state <= W_IDLE;
        endcase
      end
    end
  end

  // descriptor capture
  assign cap_we   = (state == W_FETCH) && mem_ack && !mem_err;
  assign cap_idx  = idx_q;
  assign cap_data = mem_rdata;

  // memory port
  assign mem_req   = (state == W_FETCH) || (state == W_WBACK);
  assign mem_we    = (state == W_WBACK);
  assign mem_addr  = (state == W_FETCH) ? cur_q + AW'({idx_q, 2'b00}) : cur_q;
  assign mem_wdata = {1'b0, err_q, ctrl_w[C_ERR-1:0]};

  // mover port
  assign len_field = (state == W_BUF2) ? size_w[2*LW-1:LW] : size_w[LW-1:0];
  assign mv_req    = (state == W_BUF1) || (state == W_BUF2);
  assign mv_addr   = (state == W_BUF2) ? desc[3][AW-1:0] : desc[2][AW-1:0];
  assign mv_len    = (len_field == '0) ? (LW+1)'(1) << LW : {1'b0, len_field};
  assign mv_dir    = dir_q;
  assign mv_fixed  = fix_q;
endmodule

// File: rtl/desc_dma_engine.sv
module desc_dma_engine #(
  parameter int AW = 32,
  localparam int DW = dma_pkg::WORD_W,
  localparam int NW = dma_pkg::DESC_WORDS,
  localparam int IW = $clog2(NW),
  localparam int LW = dma_pkg::LEN_W,
  localparam int SW = dma_pkg::STATUS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cfg_base,
  input  logic          cfg_enable,
  input  logic          cfg_reset,
  input  logic          cfg_dir,
  input  logic          cfg_fixburst,
  input  logic          cfg_tx_ie,
  input  logic          cfg_rx_ie,
  input  logic          sts_clr_we,
  input  logic [SW-1:0] sts_clr_mask,
  output logic [SW-1:0] status,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          mv_req,
  output logic [AW-1:0] mv_addr,
  output logic [LW:0]   mv_len,
  output logic          mv_dir,
  output logic          mv_fixed,
  input  logic          mv_done,
  input  logic          mv_err
);
  logic [NW-1:0][DW-1:0] desc;
  logic                  cap_we;
  logic [IW-1:0]         cap_idx;
  logic [DW-1:0]         cap_data;
  logic [SW-1:0]         set_vec;

  dma_desc_regs #(.NWORDS(NW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cap_we), .wr_idx(cap_idx),
    .wr_data(cap_data), .words(desc)
  );

  dma_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_enable(cfg_enable),
    .cfg_reset(cfg_reset), .cfg_dir(cfg_dir), .cfg_fixburst(cfg_fixburst),
    .desc(desc), .cap_we(cap_we), .cap_idx(cap_idx), .cap_data(cap_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len),
    .mv_dir(mv_dir), .mv_fixed(mv_fixed), .mv_done(mv_done), .mv_err(mv_err),
    .set_vec(set_vec)
  );

  dma_status #(.SW(SW)) u_stat (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_we(sts_clr_we),
    .clr_mask(sts_clr_mask), .tx_ie(cfg_tx_ie), .rx_ie(cfg_rx_ie),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/dma_checker.sv
module dma_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_reset,
  input logic          sts_clr_we,
  input logic [9:0]    status,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          mv_req,
  input logic [AW-1:0] mv_addr,
  input logic [16:0]   mv_len,
  input logic          mv_done
);
  // R3: a transfer request is held, unchanged, until done
  assert_mv_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mv_req && !mv_done && !cfg_reset) |=> (mv_req && $stable(mv_addr)));

  // R3: length always within 1..65536
  assert_mv_len_R3: assert property (@(posedge clk) disable iff (rst)
    mv_req |-> (mv_len != 17'd0 && mv_len <= 17'h10000));

  // R2: a memory access holds its address until acknowledged
  assert_mem_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !cfg_reset) |=> (mem_req && $stable(mem_addr)));

  // R12: reset pulse leaves both ports quiet on the next cycle
  assert_abort_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    cfg_reset |=> (!mem_req && !mv_req));

  // R10: without a clear strobe no status bit falls
  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !sts_clr_we |=> (($past(status) & ~status) == 10'd0));

  // R8: invalid descriptor arrives with both summaries
  assert_inval_sum_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(status[4]) |-> (status[5] && status[9]));

  // the two ports are never busy together
  assert_one_port_R3: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && mv_req));
endmodule

bind desc_dma_engine dma_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cfg_reset(cfg_reset), .sts_clr_we(sts_clr_we),
  .status(status), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len), .mv_done(mv_done)
);

// File: tb/tb_desc_dma_engine.sv
module tb_desc_dma_engine;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic [31:0] cfg_base = '0;
  logic        cfg_enable = 0, cfg_reset = 0, cfg_dir = 0, cfg_fixburst = 0;
  logic        cfg_tx_ie = 1, cfg_rx_ie = 0;
  logic        sts_clr_we = 0;
  logic [9:0]  sts_clr_mask = '0;
  logic [9:0]  status;
  logic        irq, mem_req, mem_we, mem_ack = 0, mem_err = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        mv_req, mv_dir, mv_fixed, mv_done = 0, mv_err = 0;
  logic [31:0] mv_addr;
  logic [16:0] mv_len;

  desc_dma_engine dut (.*);

  // memory model
  logic [31:0] mem [0:255];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic        log_clr = 0;
  logic [31:0] rd_log [0:3];
  int          rd_n = 0;
  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    mem_err <= mem_req && !mem_ack && (mem_addr == err_addr);
    if (mem_req && !mem_ack) begin
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we && mem_addr != err_addr) mem[mem_addr[9:2]] <= mem_wdata;
      if (!mem_we && rd_n < 4) rd_log[rd_n] <= mem_addr;
      if (!mem_we) rd_n <= rd_n + 1;
    end
    if (log_clr) rd_n <= 0;
  end

  // mover model
  logic [31:0] merr_addr = 32'hFFFF_FFFF;
  logic [31:0] lg_addr [0:15];
  logic [16:0] lg_len [0:15];
  logic        lg_dir [0:15];
  logic        lg_fix [0:15];
  int          lg_n = 0, mv_cnt = 0;
  always @(posedge clk) begin
    mv_done <= 1'b0;
    if (mv_req && !mv_done) begin
      if (mv_cnt == 2) begin
        mv_done <= 1'b1;
        mv_err  <= (mv_addr == merr_addr);
        mv_cnt  <= 0;
        if (lg_n < 16) begin
          lg_addr[lg_n] <= mv_addr; lg_len[lg_n] <= mv_len;
          lg_dir[lg_n] <= mv_dir;   lg_fix[lg_n] <= mv_fixed;
        end
        lg_n <= lg_n + 1;
      end else mv_cnt <= mv_cnt + 1;
    end else if (!mv_req) mv_cnt <= 0;
    if (log_clr) lg_n <= 0;
  end

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk) log_clr = 1;
    @(negedge clk) log_clr = 0;
  endtask

  task automatic w1c(input logic [9:0] m);
    @(negedge clk) begin sts_clr_we = 1; sts_clr_mask = m; end
    @(negedge clk) begin sts_clr_we = 0; sts_clr_mask = '0; end
  endtask

  task automatic start_walk(input logic [31:0] base);
    @(negedge clk) begin cfg_base = base; cfg_enable = 0; end
    @(negedge clk) cfg_enable = 1;
    @(negedge clk) cfg_enable = 0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    for (int t = 0; t < 3000 && q < 10; t++) begin
      @(negedge clk);
      if (mem_req || mv_req) q = 0; else q++;
    end
  endtask

  function automatic logic [31:0] wrd(input logic [31:0] a);
    return mem[a[9:2]];
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] c, input logic [31:0] s,
                     input logic [31:0] b1, input logic [31:0] b2);
    mem[a[9:2]] = c; mem[a[9:2]+1] = s; mem[a[9:2]+2] = b1; mem[a[9:2]+3] = b2;
  endtask

  // chained sweep list: descriptor i at base + 32*i
  logic [31:0] e_addr [0:3];
  logic [16:0] e_len  [0:3];
  logic [31:0] e_ctrl [0:3];
  task automatic build_chain(input int n, input bit dic, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a, c, s;
      a = base + 32*i;
      c = 32'h8000_0010 | (i == 0 ? 32'h8 : 0);
      if (i == n-1) c = c | 32'h24 | (dic ? 32'h2 : 0); else c = c | 32'h2;
      s = (n == 3 && i == 1) ? 32'h0 : 32'(n*64 + i*4 + 4);
      e_addr[i] = 32'h1000*(i+1) + 32'(n*16);
      e_len[i]  = (s == 0) ? 17'h10000 : s[16:0];
      e_ctrl[i] = c;
      put(a, c, s | 32'hABCD_0000, e_addr[i], (i == n-1) ? 32'h0 : a + 32);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(status == 0, "R1 status", status, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(!mem_req && !mv_req, "R1 idle ports", {mem_req, mv_req}, 0);

    // chained sweep
    for (int n = 1; n <= 4; n++)
      for (int d = 0; d < 2; d++)
        for (int k = 0; k < 2; k++) begin
          logic [9:0] es;
          build_chain(n, k[0], 32'h40);
          cfg_dir = d[0]; cfg_fixburst = d[0] ^ k[0]; cfg_rx_ie = n[0];
          w1c(10'h3FF);
          clear_logs();
          start_walk(32'h40);
          wait_quiet();
          for (int w = 0; w < 4; w++)
            chk(rd_log[w] == 32'h40 + 32'(4*w), "R2 fetch address", rd_log[w], 32'h40 + 32'(4*w));
          chk(lg_n == n, "R4 transfer count", 64'(lg_n), 64'(n));
          for (int i = 0; i < n; i++) begin
            chk(lg_addr[i] == e_addr[i], "R4 buffer address", lg_addr[i], e_addr[i]);
            chk(lg_len[i] == e_len[i], "R3 length", lg_len[i], e_len[i]);
            chk(lg_dir[i] == d[0], "R3 direction", lg_dir[i], d[0]);
            chk(lg_fix[i] == (d[0] ^ k[0]), "R13 fixed burst", lg_fix[i], d[0] ^ k[0]);
            chk(wrd(32'h40 + 32*i) == (e_ctrl[i] & 32'h7FFF_FFFF), "R6 write-back",
                wrd(32'h40 + 32*i), e_ctrl[i] & 32'h7FFF_FFFF);
          end
          es = k[0] ? 10'h000 : (d[0] ? 10'h101 : 10'h102);
          chk(status == es, "R7 completion status", status, es);
          chk(irq == (!k[0] && (d[0] ? 1'b1 : n[0])), "R11 irq", irq, (!k[0] && (d[0] ? 1'b1 : n[0])));
        end

    // ring mode with two-buffer descriptors, mover error, wrap to returned descriptor
    put(32'h200, 32'h8000_0008, 32'h0030_0020, 32'h5000, 32'h6000);
    put(32'h210, 32'h8000_0000, 32'h0000_0040, 32'h7000, 32'h0);
    put(32'h220, 32'h8000_0020, 32'h0010_0000, 32'h8000, 32'h9000);
    cfg_dir = 0; cfg_rx_ie = 0; merr_addr = 32'h7000;
    w1c(10'h3FF); clear_logs();
    start_walk(32'h200);
    wait_quiet();
    merr_addr = 32'hFFFF_FFFF;
    chk(lg_n == 5, "R5 ring transfer count", 64'(lg_n), 5);
    chk(lg_addr[1] == 32'h6000 && lg_len[1] == 17'h30, "R5 second buffer", {lg_addr[1], 15'd0, lg_len[1]}, {32'h6000, 32'h30});
    chk(lg_addr[2] == 32'h7000, "R5 next at +16", lg_addr[2], 32'h7000);
    chk(lg_len[3] == 17'h10000, "R3 zero means 65536", lg_len[3], 17'h10000);
    chk(lg_addr[4] == 32'h9000 && lg_len[4] == 17'h10, "R5 ring end buffer2", {lg_addr[4], 15'd0, lg_len[4]}, {32'h9000, 32'h10});
    chk(wrd(32'h210) == 32'h4000_0000, "R6 error flag", wrd(32'h210), 32'h4000_0000);
    chk(wrd(32'h200) == 32'h0000_0008, "R6 ring write-back", wrd(32'h200), 32'h8);
    chk(status == 10'h230, "R8 invalid on wrap", status, 10'h230);
    chk(irq == 1'b1, "R11 abnormal irq", irq, 1);

    // bus error during fetch of second descriptor
    put(32'h300, 32'h8000_0018, 32'h10, 32'hA000, 32'h310);
    put(32'h310, 32'h8000_0014, 32'h20, 32'hB000, 32'h0);
    err_addr = 32'h318;
    w1c(10'h3FF); clear_logs();
    start_walk(32'h300);
    wait_quiet();
    err_addr = 32'hFFFF_FFFF;
    chk(status == 10'h224, "R9 bus error status", status, 10'h224);
    chk(lg_n == 1, "R9 walk stopped", 64'(lg_n), 1);
    chk(wrd(32'h310) == 32'h8000_0014, "R9 no write-back", wrd(32'h310), 32'h8000_0014);

    // reset pulse during the first transfer
    build_chain(4, 0, 32'h40);
    cfg_dir = 1; clear_logs();
    start_walk(32'h40);
    for (int t = 0; t < 200 && !mv_req; t++) @(negedge clk);
    cfg_reset = 1;
    @(negedge clk) cfg_reset = 0;
    chk(!mv_req && !mem_req, "R12 quiet after pulse", {mv_req, mem_req}, 0);
    wait_quiet();
    chk(lg_n == 0, "R12 no transfer done", 64'(lg_n), 0);
    chk(wrd(32'h40) == e_ctrl[0], "R12 no write-back", wrd(32'h40), e_ctrl[0]);
    chk(status == 10'h224, "R12 status kept", status, 10'h224);

    // W1C
    w1c(10'h200);
    @(negedge clk);
    chk(status == 10'h024, "R10 partial clear", status, 10'h024);
    chk(irq == 1'b0, "R11 irq after clear", irq, 0);
    w1c(10'h3FF);
    @(negedge clk);
    chk(status == 10'h000, "R10 full clear", status, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule